// File: doc/BRIEF.md
# Timer Input Pin Role Configurator

This block is the front end of a 16-bit up/down timer. Two external pins, A and B, are each synchronised and then assigned a role by a 3-bit mode field. Pin A can act as a level gate or as an edge trigger. Pin B can act as an edge trigger or as an external clock for the prescaler. In the mode that pairs the A gate with the B clock, A gates B's clock. A pin that has no role in the current mode has no effect.

The role outputs drive an 8-bit programmable prescaler, a 16-bit counter and two 16-bit registers. A trigger on A acts on register 0, and a trigger on B acts on register 1. Each register either reloads the counter from its value or captures the counter's current value, as chosen by its own control bit. The count direction is set only by a software control input. Both registers are written through a flat write port.

Top module: `pin_role_timer`

## Requirements
- R1: `mode_i` decodes to roles (A role / B role) as follows: 0 none/none, 1 none/trigger, 2 gate/none, 3 gate/trigger, 4 none/clock, 5 trigger/none, 6 gate/clock, 7 trigger/trigger.
- R2: Each pin passes through two synchronising flops. A rising edge of the synchronised level produces exactly one pulse of one cycle. A trigger-driven counter change therefore appears on the third rising clock edge after the pin rises.
- R3: With A in the gate role, the counter does not advance while A is high. It advances normally while A is low.
- R4: A trigger on A acts on register 0 only, and a trigger on B acts on register 1 only. If both request a reload in the same cycle, register 0 wins.
- R5: With `regN_cap_i`=0, a trigger loads register N into the counter. With `regN_cap_i`=1, a trigger copies the counter into register N and leaves the counter unchanged.
- R6: With B in the clock role, each rising edge of B is one prescaler enable and the internal clock is not used. In mode 6 those edges count only while A is low.
- R7: In modes where no pin supplies a clock, the prescaler is enabled on every clock cycle, subject only to the A gate.
- R8: The prescaler emits one counter tick every `presc_div_i`+1 enables.
- R9: `dir_up_i`=1 counts up and wraps from 0xFFFF to 0x0000. `dir_up_i`=0 counts down and wraps from 0x0000 to 0xFFFF. No pin affects the direction.
- R10: A pin with no role in the current mode changes neither the counter nor the registers.
- R11: After reset, the counter, both registers and the synchronisers are zero.
- R12: `reg_wr_i` writes `reg_wdata_i` into register `reg_sel_i`. A write takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Pin role mode |
| pin_a_i | input | 1 | External pin A (asynchronous) |
| pin_b_i | input | 1 | External pin B (asynchronous) |
| dir_up_i | input | 1 | Count direction, 1 = up |
| presc_div_i | input | 8 | Prescaler division value minus one |
| reg0_cap_i | input | 1 | Register 0 action: 1 capture, 0 reload |
| reg1_cap_i | input | 1 | Register 1 action: 1 capture, 0 reload |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register write select |
| reg_wdata_i | input | 16 | Register write data |
| count_o | output | 16 | Counter value |
| reg0_o | output | 16 | Register 0 value |
| reg1_o | output | 16 | Register 1 value |
| cnt_tick_o | output | 1 | Counter advance pulse |
| presc_en_o | output | 1 | Prescaler enable |
| trig0_o | output | 1 | Trigger pulse toward register 0 |
| trig1_o | output | 1 | Trigger pulse toward register 1 |

## Verification
The assertions assume that `mode_i`, `dir_up_i`, `presc_div_i` and the action bits are static software settings and change only while the pins are idle. They also assume that a pin, once high, stays high long enough to be synchronised. The stimulus changes the configuration only just after a reset or while the pins are low. It holds each pin level for at least two clock cycles. All inputs are driven on the falling clock edge.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef enum logic [2:0] {
    MODE_IDLE      = 3'd0,
    MODE_B_TRIG    = 3'd1,
    MODE_A_GATE    = 3'd2,
    MODE_GATE_TRIG = 3'd3,
    MODE_B_CLK     = 3'd4,
    MODE_A_TRIG    = 3'd5,
    MODE_GATE_CLK  = 3'd6,
    MODE_DUAL_TRIG = 3'd7
  } pin_mode_e;

  typedef struct packed {
    logic a_gate;
    logic a_trig;
    logic b_trig;
    logic b_clk;
  } pin_roles_t;

  function automatic pin_roles_t decode_roles(input logic [2:0] m);
    pin_roles_t r;
    r = '0;
    unique case (pin_mode_e'(m))
      MODE_IDLE:      ;
      MODE_B_TRIG:    r.b_trig = 1'b1;
      MODE_A_GATE:    r.a_gate = 1'b1;
      MODE_GATE_TRIG: begin r.a_gate = 1'b1; r.b_trig = 1'b1; end
      MODE_B_CLK:     r.b_clk  = 1'b1;
      MODE_A_TRIG:    r.a_trig = 1'b1;
      MODE_GATE_CLK:  begin r.a_gate = 1'b1; r.b_clk = 1'b1; end
      MODE_DUAL_TRIG: begin r.a_trig = 1'b1; r.b_trig = 1'b1; end
      default:        ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/prt_pin_sync.sv
module prt_pin_sync #(
  parameter int unsigned NPINS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] level_o,
  output logic [NPINS-1:0] rise_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pin_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign level_o[g] = s2_q;
    assign rise_o[g]  = s2_q & ~s3_q;

    // R2: edge pulse lasts one cycle
    a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[g] |=> !rise_o[g]);
  end
endmodule

// File: rtl/prt_prescaler.sv
module prt_prescaler #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (tick_o)  cnt_q <= div_i;
    else if (en_i)    cnt_q <= cnt_q - 1'b1;
  end

  // R8: after a tick the divider restarts from the programmed value
  a_r8_reload_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == $past(div_i));
  a_r8_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/prt_count_core.sv
module prt_count_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             up_i,
  input  logic             trig0_i,
  input  logic             trig1_i,
  input  logic             cap0_i,
  input  logic             cap1_i,
  input  logic             wr_i,
  input  logic             sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reg0_o,
  output logic [CNT_W-1:0] reg1_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, r0_q, r1_q;
  logic load0, load1, grab0, grab1, wr0, wr1;

  assign load0 = trig0_i & ~cap0_i;
  assign load1 = trig1_i & ~cap1_i;
  assign grab0 = trig0_i &  cap0_i;
  assign grab1 = trig1_i &  cap1_i;
  assign wr0   = wr_i & ~sel_i;
  assign wr1   = wr_i &  sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load0)  cnt_q <= r0_q;
    else if (load1)  cnt_q <= r1_q;
    else if (tick_i) cnt_q <= up_i ? cnt_q + 1'b1 : cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    r0_q <= '0;
    else if (wr0)   r0_q <= wdata_i;
    else if (grab0) r0_q <= cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    r1_q <= '0;
    else if (wr1)   r1_q <= wdata_i;
    else if (grab1) r1_q <= cnt_q;
  end

  assign count_o = cnt_q;
  assign reg0_o  = r0_q;
  assign reg1_o  = r1_q;

  a_r9_up_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && up_i && !load0 && !load1 && cnt_q == CNT_MAX) |=> cnt_q == '0);
  a_r9_down_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !up_i && !load0 && !load1 && cnt_q == '0) |=> cnt_q == CNT_MAX);
  a_r4_reg0_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load0 |=> cnt_q == $past(r0_q));
  a_r5_reload1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load1 && !load0) |=> cnt_q == $past(r1_q));
  a_r5_capture1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grab1 && !wr1) |=> r1_q == $past(cnt_q));
  a_r5_capture_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grab1 && !load0 && !tick_i) |=> $stable(cnt_q));
  a_r12_write_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr0 |=> r0_q == $past(wdata_i));
endmodule

// File: rtl/pin_role_timer.sv
module pin_role_timer
  import prt_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       mode_i,
  input  logic             pin_a_i,
  input  logic             pin_b_i,
  input  logic             dir_up_i,
  input  logic [PSC_W-1:0] presc_div_i,
  input  logic             reg0_cap_i,
  input  logic             reg1_cap_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] reg0_o,
  output logic [CNT_W-1:0] reg1_o,
  output logic             cnt_tick_o,
  output logic             presc_en_o,
  output logic             trig0_o,
  output logic             trig1_o
);
  localparam int unsigned PIN_A = 0;
  localparam int unsigned PIN_B = 1;

  pin_roles_t roles;
  logic [1:0] lvl, rise;
  logic gate_ok, presc_en, tick, trig0, trig1;

  assign roles = decode_roles(mode_i);

  prt_pin_sync #(.NPINS(2)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   ({pin_b_i, pin_a_i}),
    .level_o (lvl),
    .rise_o  (rise)
  );

  // gate passes while A is low
  assign gate_ok  = ~roles.a_gate | ~lvl[PIN_A];
  assign presc_en = gate_ok & (roles.b_clk ? rise[PIN_B] : 1'b1);
  assign trig0    = roles.a_trig & rise[PIN_A];
  assign trig1    = roles.b_trig & rise[PIN_B];

  prt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (presc_en),
    .div_i  (presc_div_i),
    .tick_o (tick)
  );

  prt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .up_i    (dir_up_i),
    .trig0_i (trig0),
    .trig1_i (trig1),
    .cap0_i  (reg0_cap_i),
    .cap1_i  (reg1_cap_i),
    .wr_i    (reg_wr_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .count_o (count_o),
    .reg0_o  (reg0_o),
    .reg1_o  (reg1_o)
  );

  assign cnt_tick_o = tick;
  assign presc_en_o = presc_en;
  assign trig0_o    = trig0;
  assign trig1_o    = trig1;

  a_r3_gate_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roles.a_gate && lvl[PIN_A]) |-> !tick);
  a_r6_clock_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (roles.b_clk && !rise[PIN_B]) |-> !tick);
  a_r10_idle_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0) |-> (!trig0 && !trig1));
  a_r4_trig_onehot_role: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig0 |-> roles.a_trig);
endmodule

// File: tb/sim_pin_role_timer.sv
`timescale 1ns/1ps
module sim_pin_role_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        pa = 1'b0, pb = 1'b0, up = 1'b1;
  logic [7:0]  div = 8'd0;
  logic        cap0 = 1'b1, cap1 = 1'b1;
  logic        wr = 1'b0, sel = 1'b0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] count, r0, r1;
  logic        tick, pen, t0, t1;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pin_role_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .pin_a_i(pa), .pin_b_i(pb),
    .dir_up_i(up), .presc_div_i(div), .reg0_cap_i(cap0), .reg1_cap_i(cap1),
    .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .count_o(count), .reg0_o(r0), .reg1_o(r1), .cnt_tick_o(tick),
    .presc_en_o(pen), .trig0_o(t0), .trig1_o(t1)
  );

  // {mode, a level, up, pad, expected delta over 24 cycles with 5 B pulses}
  localparam logic [23:0] VEC [0:14] = '{
    {3'd0, 1'b0, 1'b1, 3'd0, 16'd24},
    {3'd0, 1'b1, 1'b1, 3'd0, 16'd24},
    {3'd1, 1'b1, 1'b1, 3'd0, 16'd24},
    {3'd2, 1'b0, 1'b1, 3'd0, 16'd24},
    {3'd2, 1'b1, 1'b1, 3'd0, 16'd0},
    {3'd3, 1'b1, 1'b1, 3'd0, 16'd0},
    {3'd3, 1'b0, 1'b1, 3'd0, 16'd24},
    {3'd4, 1'b0, 1'b1, 3'd0, 16'd5},
    {3'd4, 1'b1, 1'b1, 3'd0, 16'd5},
    {3'd4, 1'b0, 1'b0, 3'd0, 16'hFFFB},
    {3'd5, 1'b1, 1'b1, 3'd0, 16'd24},
    {3'd6, 1'b0, 1'b1, 3'd0, 16'd5},
    {3'd6, 1'b1, 1'b1, 3'd0, 16'd0},
    {3'd7, 1'b0, 1'b1, 3'd0, 16'd24},
    {3'd2, 1'b0, 1'b0, 3'd0, 16'hFFE8}
  };

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pa = 1'b0; pb = 1'b0; wr = 1'b0;
    wait_n(2);
    rst_n = 1'b1;
  endtask

  task automatic pulse_a();
    pa = 1'b1; wait_n(2); pa = 1'b0; wait_n(2);
  endtask

  task automatic pulse_b();
    pb = 1'b1; wait_n(2); pb = 1'b0; wait_n(2);
  endtask

  task automatic write_reg(input logic s, input logic [15:0] d);
    sel = s; wdata = d; wr = 1'b1;
    wait_n(1);
    wr = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] c0, c1, d;
    string tag;

    // R11: reset state
    wait_n(3);
    check(count == 16'd0 && r0 == 16'd0 && r1 == 16'd0, "R11 reset", count, 16'd0);
    check(!t0 && !t1, "R11 reset trig", {14'd0, t1, t0}, 16'd0);
    rst_n = 1'b1;

    // R1 role table walk
    for (int v = 0; v < 15; v++) begin
      do_reset();
      cap0 = 1'b1; cap1 = 1'b1; div = 8'd0;
      mode = VEC[v][23:21]; pa = VEC[v][20]; up = VEC[v][19];
      wait_n(6);
      c0 = count;
      for (int p = 0; p < 5; p++) pulse_b();
      wait_n(4);
      c1 = count;
      d = c1 - c0;
      if (mode == 3'd4 || mode == 3'd6) tag = "R1 R6 clock";
      else if ((mode == 3'd2 || mode == 3'd3) && VEC[v][20]) tag = "R1 R3 gate";
      else if (!VEC[v][19]) tag = "R1 R9 down";
      else tag = "R1 R7 internal";
      check(d == VEC[v][15:0], tag, d, VEC[v][15:0]);
    end

    // R8: division by 4 over 40 enables
    do_reset();
    mode = 3'd0; up = 1'b1; div = 8'd3;
    wait_n(4);
    c0 = count;
    wait_n(40);
    d = count - c0;
    check(d == 16'd10, "R8 prescale", d, 16'd10);

    // R2 and R5 reload on B: latency of three edges
    do_reset();
    mode = 3'd3; div = 8'd0; up = 1'b1; cap1 = 1'b0; pa = 1'b1;
    write_reg(1'b1, 16'h1234);
    wait_n(6);
    c0 = count;
    pb = 1'b1;
    wait_n(2);
    check(count == c0, "R2 latency early", count, c0);
    wait_n(1);
    check(count == 16'h1234, "R2 R5 reload on B", count, 16'h1234);
    wait_n(4);
    pb = 1'b0;
    check(count == 16'h1234, "R2 single pulse", count, 16'h1234);
    wait_n(3);

    // R5 capture on B, counter frozen by gate
    cap1 = 1'b1;
    write_reg(1'b0, 16'h0F0F);
    c0 = count;
    pulse_b();
    wait_n(2);
    check(r1 == c0, "R5 capture", r1, c0);
    check(count == c0, "R5 capture keeps count", count, c0);
    check(r0 == 16'h0F0F, "R12 write reg0", r0, 16'h0F0F);

    // R4 A trigger reloads register 0
    do_reset();
    mode = 3'd5; div = 8'd255; up = 1'b1; cap0 = 1'b0; cap1 = 1'b0;
    write_reg(1'b0, 16'hABCD);
    write_reg(1'b1, 16'h5555);
    pulse_a();
    wait_n(2);
    check(count == 16'hABCD || count == 16'hABCE, "R4 A reload", count, 16'hABCD);

    // R10: pin B unused in mode 5, pin A unused in mode 1
    c0 = count;
    pulse_b(); wait_n(2);
    check(count == c0 || count == c0 + 16'd1, "R10 B unused", count, c0);
    do_reset();
    mode = 3'd1; div = 8'd255; cap0 = 1'b0;
    write_reg(1'b0, 16'h7777);
    pulse_a(); wait_n(3);
    check(count < 16'h0010, "R10 A unused", count, 16'h0000);

    // R9 up wrap
    do_reset();
    mode = 3'd5; div = 8'd255; up = 1'b1; cap0 = 1'b0;
    write_reg(1'b0, 16'hFFFF);
    pulse_a();
    for (int i = 0; i < 600 && count == 16'hFFFF; i++) wait_n(1);
    check(count == 16'h0000, "R9 up wrap", count, 16'h0000);

    // R9 down wrap
    do_reset();
    mode = 3'd5; div = 8'd255; up = 1'b0; cap0 = 1'b0;
    write_reg(1'b0, 16'h0000);
    wait_n(300);
    pulse_a();
    for (int i = 0; i < 600 && count == 16'h0000; i++) wait_n(1);
    check(count == 16'hFFFF, "R9 down wrap", count, 16'hFFFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule